// File: doc/BRIEF.md
# Exponent-Driven Float-to-Fixed Converter

This block undoes the range compression introduced by an external amplifier whose gain moves in 6 dB steps. Each sample pair arrives from a quadrature mixer as two signed mantissas, in-phase and quadrature. With the pair comes a small exponent from the gain-control loop. One exponent step stands for one 6 dB gain step, which is exactly one bit of shift. The block scales both mantissas by two to the power of the exponent and hands a wider signed fixed-point pair to the decimation filters that follow.

A control bit can override the loop and pin the exponent at its largest value. A synchronous flush empties the output stage. There is one cycle of latency: each accepted pair appears on the clock edge after it was presented, with its own exponent applied.

Top module: `exr_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_vld is 0 and out_i and out_q are 0.
- R2: For a pair accepted with exponent e (0 to 7), out_i equals in_i × 2^e and out_q equals in_q × 2^e, both read as signed two's-complement values.
- R3: Outputs are 22-bit signed and sign-extended. The extreme mantissas -16384 and +16383 shifted by 7 give -2097152 and +2097024 with no wrap.
- R4: When exp_inhibit is 1 at acceptance, the exponent used is 7 whatever value in_exp carries.
- R5: The I and Q results of one pair are always scaled by the same exponent.
- R6: out_vld is 1 in the cycle after in_vld is 1 without flush, and 0 in the cycle after in_vld is 0.
- R7: When in_vld is 0, out_i and out_q keep their previous values, whatever in_i, in_q and in_exp do.
- R8: A flush of 1 clears out_i and out_q to 0 and drives out_vld to 0 on the next edge, even when in_vld is 1 in the same cycle.
- R9: An exponent change takes effect on exactly the pair that carries it: back-to-back pairs with different exponents are each scaled by their own exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of the output stage |
| in_vld | input | 1 | Input pair valid strobe |
| in_i | input | 15 | In-phase mantissa, signed |
| in_q | input | 15 | Quadrature mantissa, signed |
| in_exp | input | 3 | Exponent from the gain loop |
| exp_inhibit | input | 1 | Forces the exponent to 7 |
| out_vld | output | 1 | Output pair valid strobe |
| out_i | output | 22 | Scaled in-phase result, signed |
| out_q | output | 22 | Scaled quadrature result, signed |

## Verification
On every cycle the assertions check several properties: the one-cycle strobe relation, that flush empties the output, that outputs hold while idle, and that the inhibit bit pins the stored exponent. They also check that each valid result carries the sign of its mantissa and has zeros below the applied shift. Only the bench scenarios can show the exact scaled values. These cover both extreme mantissas at shift 7, back-to-back pairs whose exponents differ, and the I and Q lanes sharing one exponent.

// File: rtl/exr_pkg.sv
package exr_pkg;
  localparam int EXR_MANT_W = 15;
  localparam int EXR_EXP_W  = 3;
  localparam int EXR_OUT_W  = EXR_MANT_W + (1 << EXR_EXP_W) - 1;

  typedef enum logic {LANE_I = 1'b0, LANE_Q = 1'b1} exr_lane_e;
endpackage

// File: rtl/exr_exp_select.sv
module exr_exp_select #(
  parameter int EXP_W = exr_pkg::EXR_EXP_W
) (
  input  logic [EXP_W-1:0] loop_exp,
  input  logic             inhibit,
  output logic [EXP_W-1:0] eff_exp
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  always_comb begin
    eff_exp = inhibit ? EXP_MAX : loop_exp;
  end
endmodule

// File: rtl/exr_shift_lane.sv
module exr_shift_lane #(
  parameter int MANT_W = exr_pkg::EXR_MANT_W,
  parameter int EXP_W  = exr_pkg::EXR_EXP_W,
  parameter int OUT_W  = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  shamt,
  output logic [OUT_W-1:0]  res
);
  localparam int EXT_W = OUT_W - MANT_W;

  function automatic logic [OUT_W-1:0] widen_shift(
    input logic [MANT_W-1:0] m,
    input logic [EXP_W-1:0]  s
  );
    logic signed [OUT_W-1:0] ext;
    ext = $signed({{EXT_W{m[MANT_W-1]}}, m});
    return ext <<< s;
  endfunction

  logic [OUT_W-1:0] shifted;
  assign shifted = widen_shift(mant, shamt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (flush) begin
      res <= '0;
    end else if (load) begin
      res <= shifted;
    end
  end
endmodule

// File: rtl/exr_top.sv
module exr_top #(
  parameter int MANT_W = exr_pkg::EXR_MANT_W,
  parameter int EXP_W  = exr_pkg::EXR_EXP_W,
  parameter int OUT_W  = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_vld,
  input  logic [MANT_W-1:0] in_i,
  input  logic [MANT_W-1:0] in_q,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              exp_inhibit,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_i,
  output logic [OUT_W-1:0]  out_q
);
  localparam int NLANES = 2;

  logic [EXP_W-1:0]  eff_exp;
  logic [EXP_W-1:0]  exp_applied;
  logic              accept;
  logic [MANT_W-1:0] lane_in  [NLANES];
  logic [OUT_W-1:0]  lane_out [NLANES];

  assign accept = in_vld && !flush;

  exr_exp_select #(.EXP_W(EXP_W)) u_sel (
    .loop_exp (in_exp),
    .inhibit  (exp_inhibit),
    .eff_exp  (eff_exp)
  );

  assign lane_in[exr_pkg::LANE_I] = in_i;
  assign lane_in[exr_pkg::LANE_Q] = in_q;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    exr_shift_lane #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .load  (accept),
      .mant  (lane_in[g]),
      .shamt (eff_exp),
      .res   (lane_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld     <= 1'b0;
      exp_applied <= '0;
    end else begin
      out_vld <= accept;
      if (flush) exp_applied <= '0;
      else if (in_vld) exp_applied <= eff_exp;
    end
  end

  assign out_i = lane_out[exr_pkg::LANE_I];
  assign out_q = lane_out[exr_pkg::LANE_Q];
endmodule

// File: rtl/exr_checker.sv
module exr_checker #(
  parameter int MANT_W = exr_pkg::EXR_MANT_W,
  parameter int EXP_W  = exr_pkg::EXR_EXP_W,
  parameter int OUT_W  = MANT_W + (1 << EXP_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_vld,
  input logic [MANT_W-1:0] in_i,
  input logic [MANT_W-1:0] in_q,
  input logic              exp_inhibit,
  input logic              out_vld,
  input logic [OUT_W-1:0]  out_i,
  input logic [OUT_W-1:0]  out_q,
  input logic [EXP_W-1:0]  exp_applied
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic [OUT_W-1:0] low_mask;
  assign low_mask = ({{(OUT_W-1){1'b0}}, 1'b1} << exp_applied) - 1'b1;

  assert_vld_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !flush) |=> out_vld);
  assert_vld_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld || flush) |=> !out_vld);
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_i == '0 && out_q == '0));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !flush) |=> ($stable(out_i) && $stable(out_q)));
  assert_inhibit_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !flush && exp_inhibit) |=> exp_applied == EXP_MAX);
  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !flush) |=> (out_i[OUT_W-1] == $past(in_i[MANT_W-1]) &&
                            out_q[OUT_W-1] == $past(in_q[MANT_W-1])));
  assert_shared_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((out_i & low_mask) == '0 && (out_q & low_mask) == '0));
endmodule

bind exr_top exr_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_vld      (in_vld),
  .in_i        (in_i),
  .in_q        (in_q),
  .exp_inhibit (exp_inhibit),
  .out_vld     (out_vld),
  .out_i       (out_i),
  .out_q       (out_q),
  .exp_applied (exp_applied)
);

// File: tb/sim_exr_top.sv
`timescale 1ns/1ps
module sim_exr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_vld = 1'b0;
  logic [14:0] in_i = '0;
  logic [14:0] in_q = '0;
  logic [2:0]  in_exp = '0;
  logic        exp_inhibit = 1'b0;
  logic        out_vld;
  logic [21:0] out_i;
  logic [21:0] out_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exr_top u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld),
    .in_i(in_i), .in_q(in_q), .in_exp(in_exp), .exp_inhibit(exp_inhibit),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int scaled(input int m, input int e);
    return m * (2 ** e);
  endfunction

  function automatic int sv22(input logic [21:0] v);
    return int'($signed(v));
  endfunction

  task automatic present(input int i, input int q, input int e, input bit inh);
    in_vld = 1'b1;
    in_i = 15'(i);
    in_q = 15'(q);
    in_exp = 3'(e);
    exp_inhibit = inh;
  endtask

  task automatic idle();
    in_vld = 1'b0;
    exp_inhibit = 1'b0;
  endtask

  task automatic check_pair(input string tag, input int i, input int q, input int e);
    chk({tag, " vld"}, int'(out_vld), 1);
    chk({tag, " I"}, sv22(out_i), scaled(i, e));
    chk({tag, " Q"}, sv22(out_q), scaled(q, e));
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 vld in reset", int'(out_vld), 0);
    chk("R1 I in reset", sv22(out_i), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", int'(out_vld), 0);
    chk("R1 Q after reset", sv22(out_q), 0);
  endtask

  task automatic t_scale_R2();
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      present(1234 - 300 * e, -987 + 211 * e, e, 1'b0);
      @(negedge clk);
      idle();
      check_pair("R2 R5 scale", 1234 - 300 * e, -987 + 211 * e, e);
    end
  endtask

  task automatic t_extremes_R3();
    @(negedge clk);
    present(-16384, 16383, 7, 1'b0);
    @(negedge clk);
    idle();
    check_pair("R3 extremes", -16384, 16383, 7);
    @(negedge clk);
    present(-1, 1, 7, 1'b0);
    @(negedge clk);
    idle();
    check_pair("R3 small", -1, 1, 7);
  endtask

  task automatic t_inhibit_R4();
    @(negedge clk);
    present(100, -55, 2, 1'b1);
    @(negedge clk);
    idle();
    check_pair("R4 inhibit", 100, -55, 7);
    @(negedge clk);
    present(100, -55, 2, 1'b0);
    @(negedge clk);
    idle();
    check_pair("R4 released", 100, -55, 2);
  endtask

  task automatic t_strobe_R6();
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R6 vld low after idle", int'(out_vld), 0);
  endtask

  task automatic t_hold_R7();
    int hi, hq;
    @(negedge clk);
    present(321, -654, 3, 1'b0);
    @(negedge clk);
    idle();
    hi = sv22(out_i);
    hq = sv22(out_q);
    for (int k = 0; k < 4; k++) begin
      in_i = 15'(k * 777);
      in_q = 15'(-k * 91);
      in_exp = 3'(k);
      @(negedge clk);
      chk("R7 hold I", sv22(out_i), hi);
      chk("R7 hold Q", sv22(out_q), hq);
      chk("R7 vld low", int'(out_vld), 0);
    end
  endtask

  task automatic t_flush_R8();
    @(negedge clk);
    present(500, 600, 4, 1'b0);
    @(negedge clk);
    present(700, 800, 5, 1'b0);
    flush = 1'b1;
    @(negedge clk);
    idle();
    flush = 1'b0;
    chk("R8 flush vld", int'(out_vld), 0);
    chk("R8 flush I", sv22(out_i), 0);
    chk("R8 flush Q", sv22(out_q), 0);
  endtask

  task automatic t_b2b_R9();
    @(negedge clk);
    present(3000, -3000, 1, 1'b0);
    @(negedge clk);
    present(-2500, 2500, 6, 1'b0);
    check_pair("R9 first", 3000, -3000, 1);
    @(negedge clk);
    present(77, 88, 0, 1'b0);
    check_pair("R9 second", -2500, 2500, 6);
    @(negedge clk);
    idle();
    check_pair("R9 third", 77, 88, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_R1();
    t_scale_R2();
    t_extremes_R3();
    t_inhibit_R4();
    t_strobe_R6();
    t_hold_R7();
    t_flush_R8();
    t_b2b_R9();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule